// File: doc/BRIEF.md
# One-Time-Programmable Memory Programming Sequencer

This block drives the parallel programming pins of an external one-time-programmable code memory. A host hands it one address/data pair at a time over a valid/ready handshake. For each pair the sequencer places the 12-bit address on two output groups (low byte and high nibble), turns the data port to output with the byte on it, raises the program-mode control line, and then the high-voltage enable. Only then does it send a fixed burst of five active-low program strobes. No adaptive pulse-until-pass loop is used.

After the burst the sequencer drops the high-voltage enable, the program-mode line and the data drive. After a hold time it raises the verify-mode line and reads the byte back from the device. It compares that byte with the one it meant to write. A one-cycle done pulse ends every byte. A fail pulse goes with done when the bytes differ, and a sticky error flag records that any byte failed. A failure does not stall the stream. All delays are counted in clock cycles and set by parameters.

Back-pressure: `in_ready` is high only while the sequencer is idle. A pair is taken on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` then stays low until the cycle after that byte's done pulse. `in_valid` seen while `in_ready` is low is ignored. The host may hold `in_valid` high, and the pair is taken as soon as the sequencer is idle again.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset `in_ready`=1, `dev_hv_en`=0, `dev_pgm_en`=0, `dev_chk_en`=0, `dev_data_oe`=0, `dev_strobe_n`=1, `done`=0, `fail`=0, `sticky_err`=0.
- R2: A pair is accepted only on an edge with `in_valid` and `in_ready` both high. `in_ready` is low from the next cycle until the cycle after `done`. `in_valid` pulsed while `in_ready` is low starts no programming cycle.
- R3: During a byte `dev_addr_lo` carries address bits 7:0, `dev_addr_hi` carries address bits 11:8, and `dev_data_out` carries the accepted data byte.
- R4: The address is set first. `dev_data_oe` rises SETUP_CYC cycles later. `dev_pgm_en` rises SETUP_CYC cycles after that, `dev_hv_en` SETUP_CYC cycles after that, and the first strobe falls SETUP_CYC cycles after `dev_hv_en`. The strobe is low only while `dev_hv_en`, `dev_pgm_en` and `dev_data_oe` are all high.
- R5: Exactly NUM_PULSES (default 5) strobe pulses are issued per byte. Each is low for PULSE_LO cycles, and falling edges are PULSE_LO+PULSE_HI cycles apart.
- R6: After the last pulse `dev_hv_en`, `dev_pgm_en` and `dev_data_oe` fall together. `dev_chk_en` rises HOLD_CYC cycles later and is never high while `dev_hv_en` or `dev_data_oe` is high.
- R7: `dev_chk_en` stays high for SETUP_CYC cycles. `dev_data_in` is sampled in its last cycle and compared with the accepted byte.
- R8: `done` is a one-cycle pulse once per accepted byte, in the cycle after `dev_chk_en` falls. `fail` is high in that cycle exactly when the read-back byte differed, and never otherwise.
- R9: `sticky_err` is set by the first failing byte and stays set until reset. Later bytes are still accepted and programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Host offers an address/data pair |
| in_ready | output | 1 | Sequencer idle, pair will be taken |
| in_addr | input | 12 | Byte address |
| in_data | input | 8 | Byte to program |
| dev_addr_lo | output | 8 | Address bits 7:0 to device |
| dev_addr_hi | output | 4 | Address bits 11:8 to device |
| dev_data_out | output | 8 | Data driven toward device |
| dev_data_oe | output | 1 | Data port drive enable (1 = output) |
| dev_data_in | input | 8 | Data read from device |
| dev_pgm_en | output | 1 | Program-mode control pattern |
| dev_hv_en | output | 1 | High-voltage enable |
| dev_strobe_n | output | 1 | Active-low program strobe |
| dev_chk_en | output | 1 | Verify-mode control pattern |
| done | output | 1 | Byte program-and-verify finished (pulse) |
| fail | output | 1 | Read-back mismatch for this byte (pulse) |
| sticky_err | output | 1 | Some byte failed since reset |

## Verification
The main path is driven with a table of pairs whose addresses cover all-zero, all-one, mixed nibble patterns and the top address bit alone. This separates the two address groups and catches swapped or shifted bits. The data bytes include 00, FF and alternating patterns, checked against a device model that stores whatever is strobed in. Some rows make the model corrupt the read-back, by one low bit or by the top bit. These rows tell a real compare apart from a stuck pass. A passing byte after a failing one shows that the error flag is sticky and that the stream keeps going. A `in_valid` pulse during a busy cycle, at an address never used elsewhere, shows whether back-pressure really ignores it.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_CTRL, ST_HVON,
    ST_PLO, ST_PHI, ST_HVOFF, ST_VFY, ST_DONE
  } seq_state_t;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign zero = (cnt == '0);
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally #(
  parameter int N = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (inc)  cnt <= cnt + 1'b1;
  end
  assign last = (cnt == CW'(N - 1));
endmodule

// File: rtl/vfy_cmp.sv
module vfy_cmp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] expected,
  input  logic [DW-1:0] observed,
  output logic          mismatch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mismatch <= 1'b0;
    else if (capture)  mismatch <= (expected != observed);
  end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 2,
  parameter int HOLD_CYC   = 2,
  parameter int PULSE_LO   = 3,
  parameter int PULSE_HI   = 2,
  parameter int NUM_PULSES = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic [7:0]    dev_addr_lo,
  output logic [AW-9:0] dev_addr_hi,
  output logic [DW-1:0] dev_data_out,
  output logic          dev_data_oe,
  input  logic [DW-1:0] dev_data_in,
  output logic          dev_pgm_en,
  output logic          dev_hv_en,
  output logic          dev_strobe_n,
  output logic          dev_chk_en,
  output logic          done,
  output logic          fail,
  output logic          sticky_err
);
  localparam int M1   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int M2   = (PULSE_LO > PULSE_HI) ? PULSE_LO : PULSE_HI;
  localparam int MAXD = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(MAXD + 1);
  localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] T_LO    = TW'(PULSE_LO - 1);
  localparam logic [TW-1:0] T_HI    = TW'(PULSE_HI - 1);

  seq_state_t state, nxt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          t_load, t_zero, p_clr, p_inc, p_last, cap, mism;
  logic [TW-1:0] t_val;

  seq_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  pulse_tally #(.N(NUM_PULSES)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(p_clr), .inc(p_inc), .last(p_last)
  );

  vfy_cmp #(.DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .capture(cap),
    .expected(data_q), .observed(dev_data_in), .mismatch(mism)
  );

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = T_SETUP;
    p_clr  = 1'b0;
    p_inc  = 1'b0;
    cap    = 1'b0;
    case (state)
      ST_IDLE:  if (in_valid) begin nxt = ST_ADDR; t_load = 1'b1; p_clr = 1'b1; end
      ST_ADDR:  if (t_zero) begin nxt = ST_DATA; t_load = 1'b1; end
      ST_DATA:  if (t_zero) begin nxt = ST_CTRL; t_load = 1'b1; end
      ST_CTRL:  if (t_zero) begin nxt = ST_HVON; t_load = 1'b1; end
      ST_HVON:  if (t_zero) begin nxt = ST_PLO; t_load = 1'b1; t_val = T_LO; end
      ST_PLO:   if (t_zero) begin nxt = ST_PHI; t_load = 1'b1; t_val = T_HI; end
      ST_PHI:   if (t_zero) begin
                  t_load = 1'b1;
                  if (p_last) begin nxt = ST_HVOFF; t_val = T_HOLD; end
                  else begin nxt = ST_PLO; t_val = T_LO; p_inc = 1'b1; end
                end
      ST_HVOFF: if (t_zero) begin nxt = ST_VFY; t_load = 1'b1; end
      ST_VFY:   if (t_zero) begin nxt = ST_DONE; cap = 1'b1; end
      ST_DONE:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      sticky_err <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && in_valid) begin
        addr_q <= in_addr;
        data_q <= in_data;
      end
      if (state == ST_DONE && mism) sticky_err <= 1'b1;
    end
  end

  assign in_ready     = (state == ST_IDLE);
  assign dev_addr_lo  = addr_q[7:0];
  assign dev_addr_hi  = addr_q[AW-1:8];
  assign dev_data_out = data_q;
  assign dev_data_oe  = (state inside {ST_DATA, ST_CTRL, ST_HVON, ST_PLO, ST_PHI});
  assign dev_pgm_en   = (state inside {ST_CTRL, ST_HVON, ST_PLO, ST_PHI});
  assign dev_hv_en    = (state inside {ST_HVON, ST_PLO, ST_PHI});
  assign dev_strobe_n = (state != ST_PLO);
  assign dev_chk_en   = (state == ST_VFY);
  assign done         = (state == ST_DONE);
  assign fail         = (state == ST_DONE) && mism;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic dev_data_oe,
  input logic dev_pgm_en,
  input logic dev_hv_en,
  input logic dev_strobe_n,
  input logic dev_chk_en,
  input logic done,
  input logic fail,
  input logic sticky_err
);
  p_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_strobe_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_strobe_n |-> (dev_hv_en && dev_pgm_en && dev_data_oe));
  p_hv_after_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_hv_en) |-> (dev_pgm_en && dev_data_oe));
  p_verify_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dev_chk_en |-> (!dev_hv_en && !dev_data_oe && !dev_pgm_en));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fail_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_err |=> sticky_err);
endmodule

bind otp_prog_seq otp_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .dev_data_oe(dev_data_oe), .dev_pgm_en(dev_pgm_en), .dev_hv_en(dev_hv_en),
  .dev_strobe_n(dev_strobe_n), .dev_chk_en(dev_chk_en), .done(done),
  .fail(fail), .sticky_err(sticky_err)
);

// File: tb/otp_prog_seq_tb.sv
module otp_prog_seq_tb_top;
  localparam int SETUP = 2, HOLD = 2, PLO = 3, PHI = 2, NP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [11:0] in_addr = '0;
  logic [7:0]  in_data = '0, dev_data_out, dev_data_in = 8'hFF;
  logic [7:0]  dev_addr_lo;
  logic [3:0]  dev_addr_hi;
  logic dev_data_oe, dev_pgm_en, dev_hv_en, dev_strobe_n, dev_chk_en;
  logic done, fail, sticky_err;

  always #10 clk = ~clk;

  otp_prog_seq #(.SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .PULSE_LO(PLO),
                 .PULSE_HI(PHI), .NUM_PULSES(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .dev_addr_lo(dev_addr_lo),
    .dev_addr_hi(dev_addr_hi), .dev_data_out(dev_data_out),
    .dev_data_oe(dev_data_oe), .dev_data_in(dev_data_in),
    .dev_pgm_en(dev_pgm_en), .dev_hv_en(dev_hv_en),
    .dev_strobe_n(dev_strobe_n), .dev_chk_en(dev_chk_en),
    .done(done), .fail(fail), .sticky_err(sticky_err));

  int tests = 0, fails = 0;
  int cyc = 0;
  // device model and monitors, all sampled at the falling edge
  logic [7:0] mem [logic [11:0]];
  logic [7:0] corrupt = 8'h00;
  int pulses = 0, err_gate = 0, err_width = 0, err_order = 0, err_vfy = 0;
  int done_cnt = 0, last_fail = 0;
  int t_oe = 0, t_pgm = 0, t_hv = 0, t_hv_off = 0, t_fall = 0, lo_len = 0;
  logic p_strobe = 1'b1, p_oe = 1'b0, p_pgm = 1'b0, p_hv = 1'b0, p_chk = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (dev_data_oe && !p_oe) t_oe = cyc;
      if (dev_pgm_en && !p_pgm && (cyc - t_oe != SETUP)) err_order++;
      if (dev_pgm_en && !p_pgm) t_pgm = cyc;
      if (dev_hv_en && !p_hv && (cyc - t_pgm != SETUP)) err_order++;
      if (dev_hv_en && !p_hv) t_hv = cyc;
      if (!dev_hv_en && p_hv) begin
        t_hv_off = cyc;
        if (dev_pgm_en || dev_data_oe) err_order++;
      end
      if (!dev_strobe_n) begin
        if (!(dev_hv_en && dev_pgm_en && dev_data_oe)) err_gate++;
        lo_len++;
      end
      if (!dev_strobe_n && p_strobe) begin
        if (pulses == 0 && (cyc - t_hv != SETUP)) err_order++;
        if (pulses != 0 && (cyc - t_fall != PLO + PHI)) err_width++;
        t_fall = cyc;
        pulses++;
        mem[{dev_addr_hi, dev_addr_lo}] = dev_data_out;
      end
      if (dev_strobe_n && !p_strobe) begin
        if (lo_len != PLO) err_width++;
        lo_len = 0;
      end
      if (dev_chk_en && !p_chk && (cyc - t_hv_off != HOLD)) err_vfy++;
      if (dev_chk_en && (dev_hv_en || dev_data_oe)) err_vfy++;
      if (dev_chk_en && mem.exists({dev_addr_hi, dev_addr_lo}))
        dev_data_in = mem[{dev_addr_hi, dev_addr_lo}] ^ corrupt;
      else
        dev_data_in = 8'hFF;
      if (done) begin done_cnt++; last_fail = int'(fail); end
      else if (fail) err_vfy++;
    end
    p_strobe = dev_strobe_n; p_oe = dev_data_oe; p_pgm = dev_pgm_en;
    p_hv = dev_hv_en; p_chk = dev_chk_en;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_byte(input logic [11:0] a, input logic [7:0] d,
                          input logic [7:0] cor);
    int start_done;
    corrupt = cor;
    pulses = 0;
    start_done = done_cnt;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 200 && done_cnt == start_done; k++) @(negedge clk);
    check("R8 done count", done_cnt - start_done, 1);
  endtask

  // {addr, data, read-back corruption}
  localparam logic [27:0] VEC [6] = '{
    {12'h000, 8'h00, 8'h00},
    {12'hFFF, 8'hFF, 8'h00},
    {12'h5A3, 8'hC3, 8'h00},
    {12'h0A5, 8'h5A, 8'h01},
    {12'h800, 8'h80, 8'h00},
    {12'h3C7, 8'h7E, 8'h80}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 hv_en", int'(dev_hv_en), 0);
    check("R1 strobe_n", int'(dev_strobe_n), 1);
    check("R1 oe/pgm/chk", int'({dev_data_oe, dev_pgm_en, dev_chk_en}), 0);
    check("R1 done/fail/sticky", int'({done, fail, sticky_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [11:0] a; logic [7:0] d, c;
      a = VEC[i][27:16]; d = VEC[i][15:8]; c = VEC[i][7:0];
      run_byte(a, d, c);
      check("R5 pulse count", pulses, NP);
      check("R3 byte at split address", mem.exists(a) ? int'(mem[a]) : -1, int'(d));
      check("R7/R8 fail flag", last_fail, (c != 0) ? 1 : 0);
    end
    check("R4 strobe gating", err_gate, 0);
    check("R4 step spacing", err_order, 0);
    check("R5 strobe widths", err_width, 0);
    check("R6 verify quiet/hold", err_vfy, 0);
    check("R9 sticky after fail", int'(sticky_err), 1);

    // R2: valid during busy is ignored
    corrupt = 8'h00;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_addr = 12'h111; in_data = 8'h11;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 ready low while busy", int'(in_ready), 0);
    in_valid = 1'b1; in_addr = 12'hABC; in_data = 8'h22;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 200 && !in_ready; k++) @(negedge clk);
    repeat (60) @(negedge clk);
    check("R2 busy request dropped", int'(mem.exists(12'hABC)), 0);
    check("R2 accepted byte", mem.exists(12'h111) ? int'(mem[12'h111]) : -1, 8'h11);

    // R9 passing byte keeps sticky, stream continues
    run_byte(12'h246, 8'hA5, 8'h00);
    check("R9 continues after fail", last_fail, 0);
    check("R9 sticky held", int'(sticky_err), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9/R1 sticky cleared by reset", int'(sticky_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule